// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous host to an external asynchronous static RAM of 256K words by 16 bits. The host presents a one-cycle request carrying an address, a read/write flag, write data and a per-byte lane mask. The controller then runs the memory's active-low chip-select, write-strobe, output-strobe and per-lane byte-select pins. It holds each phase for enough clock cycles to cover the memory's 45 ns minimum cycle. It also decides who drives the shared bidirectional data bus.

A write asserts the write strobe for the whole access phase, with the requested lanes selected, and the controller drives the bus. A read first spends one turnaround cycle with the bus released and the output strobe still high. It then lowers the output strobe for the access phase and registers the bus in the final cycle of that phase. Lanes that are not selected come back as zero. After either kind of access, one cycle with the memory deselected carries a single-cycle done pulse. Requests are only taken while the controller is idle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and right after it, chip select, write strobe, output strobe and both byte selects are high, done is low and read data is zero.
- R2: Outside an access, and in the done cycle, chip select, write strobe, output strobe and both byte selects are high.
- R3: A write holds chip select and write strobe low, and the output strobe high, for exactly ACC = ceil(CYCLE_NS / CLK_PERIOD_NS) cycles (3 at 20 ns). Byte select bit 0 (data bits 7:0) is low when mask bit 0 is 1, and byte select bit 1 (bits 15:8) is low when mask bit 1 is 1.
- R4: A write changes only the lanes whose mask bit is 1. A mask of 00 leaves the word unchanged.
- R5: A read spends one cycle with chip select low and both strobes high. It then holds the output strobe low, with the write strobe high, for exactly ACC cycles.
- R6: The read data returns the memory word on lanes whose mask bit is 1 and zero on the other lanes, and it stays valid after done.
- R7: During a read, only the lanes selected by the mask are enabled for the memory to drive. The other lanes stay high-impedance.
- R8: The write strobe and the output strobe are never low together, so the controller drives the bus only while the memory's outputs are off.
- R9: Done is high for exactly one cycle. It is high ACC+1 cycles after a write is accepted and ACC+2 cycles after a read is accepted.
- R10: A request presented while an access is in progress is ignored. The access in flight keeps its own address, data, mask and direction.
- R11: The memory address equals the accepted request address and stays stable for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| rsp_rdata | output | 16 | Registered read data, unselected lanes zero |
| rsp_done | output | 1 | One-cycle access-complete pulse |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_be_n | output | 2 | Byte selects, active low: bit 1 upper, bit 0 lower |
| mem_dq | inout | 16 | Bidirectional memory data bus |

## Verification
The assertions assume that reset starts the controller idle. They also assume that the attached memory drives the bus only when chip select and the output strobe are low and the write strobe is high. The bench meets this with a behavioural memory that follows the byte-lane truth table. The host may change or repeat requests during an access. The stimulus does this on purpose, re-driving random request fields while a transfer is in flight. It drops the request strobe before the controller returns to idle, so no access is accepted unintentionally.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter int CYCLE_NS      = 45,
  localparam int LANES        = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int RAW = (CYCLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int ACC = (RAW < 1) ? 1 : RAW;
  localparam int CW  = $clog2(ACC + 1);
  localparam logic [CW-1:0] LAST = CW'(ACC - 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_TURN, S_RD, S_DONE} st_t;

  st_t               state;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] lane_bits;
  logic              busy;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_bits[i*8 +: 8] = {8{mask_q[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mask_q  <= req_mask;
          cnt     <= '0;
          state   <= req_write ? S_WR : S_TURN;
        end
        S_WR: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        S_TURN: begin
          cnt   <= '0;
          state <= S_RD;
        end
        S_RD: begin
          if (cnt == LAST) begin
            rdata_q <= mem_dq & lane_bits;
            cnt     <= '0;
            state   <= S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state == S_WR) || (state == S_TURN) || (state == S_RD);
  assign mem_ce_n  = !busy;
  assign mem_we_n  = (state != S_WR);
  assign mem_oe_n  = (state != S_RD);
  assign mem_be_n  = busy ? ~mask_q : '1;
  assign mem_addr  = addr_q;
  assign mem_dq    = (state == S_WR) ? wdata_q : {DATA_W{1'bz}};
  assign rsp_done  = (state == S_DONE);
  assign rsp_rdata = rdata_q;

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  p_write_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  p_turn_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(!mem_ce_n && mem_we_n && mem_oe_n));

  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n)));

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  localparam int ACC = (45 + 20 - 1) / 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_done;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n;
  wire  [15:0] dq;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_dq(dq)
  );

  logic [15:0] mmem [256];
  logic [15:0] refm [256];
  wire  [7:0]  ai = mem_addr[7:0];
  wire  [1:0]  mdrv;
  assign mdrv[0] = !mem_ce_n && mem_we_n && !mem_oe_n && !mem_be_n[0];
  assign mdrv[1] = !mem_ce_n && mem_we_n && !mem_oe_n && !mem_be_n[1];
  assign dq[7:0]  = mdrv[0] ? mmem[ai][7:0]  : 8'hzz;
  assign dq[15:8] = mdrv[1] ? mmem[ai][15:8] : 8'hzz;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      if (!mem_be_n[0]) mmem[ai][7:0]  <= dq[7:0];
      if (!mem_be_n[1]) mmem[ai][15:8] <= dq[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit noise);
    int lat;
    logic [15:0] expd;
    lat = wr ? ACC + 1 : ACC + 2;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    if (noise) begin
      req_write = ~wr; req_addr = 18'($urandom); req_wdata = 16'($urandom); req_mask = 2'($urandom);
    end else req_valid = 1'b0;
    if (wr) refm[a[7:0]] = (refm[a[7:0]] & ~lanes(m)) | (d & lanes(m));
    expd = refm[a[7:0]] & lanes(m);
    for (int k = 1; k <= lat; k++) begin
      if (k > 1) @(negedge clk);
      if (k < lat) begin
        chk(mem_addr == a, "R11 address held", 32'(mem_addr), 32'(a));
        chk(rsp_done == 1'b0, "R9 done early", 32'(rsp_done), 0);
        if (wr) begin
          chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == {3'b001, ~m},
              "R3 write pins", 32'({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}), 32'({3'b001, ~m}));
        end else if (k == 1) begin
          chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b011, "R5 turnaround",
              32'({mem_ce_n, mem_we_n, mem_oe_n}), 32'b011);
        end else begin
          chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == {3'b010, ~m},
              "R5 read pins", 32'({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}), 32'({3'b010, ~m}));
          chk(mdrv == m, "R7 driven lanes", 32'(mdrv), 32'(m));
          chk(!(mdrv != 2'b00 && !mem_we_n), "R8 bus clash", 32'(mem_we_n), 1);
        end
      end else begin
        chk(rsp_done == 1'b1, "R9 done latency", 32'(rsp_done), 1);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == 5'b11111, "R2 deselected in done",
            32'({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}), 32'h1f);
        if (!wr) chk(rsp_rdata == expd, "R6 read data", 32'(rsp_rdata), 32'(expd));
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(rsp_done == 1'b0, "R9 single pulse", 32'(rsp_done), 0);
    chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R2 idle pins", 32'({mem_ce_n, mem_we_n, mem_oe_n}), 32'h7);
    if (!wr) chk(rsp_rdata == expd, "R6 data held", 32'(rsp_rdata), 32'(expd));
    if (noise) chk(mem_addr == a, "R10 busy request ignored", 32'(mem_addr), 32'(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [17:0] a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) refm[i] = '0;
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, rsp_done} == 6'b111110, "R1 reset pins",
        32'({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, rsp_done}), 32'h3e);
    chk(rsp_rdata == 16'h0, "R1 reset data", 32'(rsp_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == 5'b11111, "R1 after release",
        32'({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}), 32'h1f);

    for (int i = 0; i < 16; i++) access(1'b1, {10'($urandom), 8'(i)}, 16'($urandom), 2'b11, 1'b0);

    a = 18'h2A005;
    access(1'b1, a, 16'hA1B2, 2'b11, 1'b0);
    access(1'b1, a, 16'hFFC3, 2'b01, 1'b0);
    access(1'b0, a, 16'h0, 2'b11, 1'b0);
    chk(rsp_rdata == 16'hA1C3, "R4 low-lane write", 32'(rsp_rdata), 32'hA1C3);
    access(1'b1, a, 16'h5EFF, 2'b10, 1'b0);
    access(1'b1, a, 16'h0000, 2'b00, 1'b0);
    access(1'b0, a, 16'h0, 2'b11, 1'b0);
    chk(rsp_rdata == 16'h5EC3, "R4 high-lane and empty-mask write", 32'(rsp_rdata), 32'h5EC3);
    access(1'b0, a, 16'h0, 2'b01, 1'b0);
    access(1'b0, a, 16'h0, 2'b10, 1'b0);
    access(1'b0, a, 16'h0, 2'b00, 1'b0);
    access(1'b1, 18'h3FF0F, 16'h1234, 2'b11, 1'b1);
    access(1'b0, 18'h3FF0F, 16'h0, 2'b11, 1'b1);

    for (int n = 0; n < 400; n++)
      access(1'($urandom), {10'($urandom), 8'($urandom_range(0, 15))}, 16'($urandom),
             2'($urandom), 1'($urandom));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule